// File: doc/BRIEF.md
# Tri-State Phase Detector with Lock Counter

This block is the digital core of a charge-pump phase-frequency detector in a synthesizer loop. It watches the outputs of the reference divider and the main divider, finds their rising edges on the system clock, and drives two pump enables. The `up` enable is raised when the reference edge comes first, and the `down` enable when the divided oscillator edge comes first. As soon as both edges have been seen, both enables drop, so the pump is only ever driven in one direction at a time.

Each finished comparison is timed in system-clock cycles against a fixed window. A run of seven in-window comparisons in a row raises the lock flag. A single comparison outside the window clears that run. A pump current code is written through a load strobe. The code is held back until the pump is idle, then applied and turned into a current magnitude in units. A tri-state control turns off both enables and the lock detection.

Top module: `pfd_lock_top`

## Requirements
- R1: When a reference rising edge arrives with no divider edge pending, `up_o` goes high in the following cycle. It stays high until the cycle after the divider rising edge, so it is high for exactly as many cycles as the reference leads.
- R2: When a divider rising edge arrives first, `dn_o` behaves the same way: it is high for exactly as many cycles as the divider leads the reference.
- R3: `up_o` and `dn_o` are never high in the same cycle. Rising edges on both inputs in the same cycle produce no pulse on either output.
- R4: `cur_units_o` gives the applied code as a magnitude. `cur_code_o` = 2'b00 gives 50, 2'b01 (bit 0, the low step) gives 100, 2'b10 (bit 1, the high step) gives 150, and 2'b11 gives 200.
- R5: A code on `cur_code_i` is captured only when `cur_load_i` pulses. If the pump is idle, it appears on `cur_code_o` two cycles after the strobe. It never changes while `up_o` or `dn_o` is high, nor in the cycle just after either was high.
- R6: While `tri_i` is high, `up_o` and `dn_o` are low from the next cycle on, and divider and reference edges are ignored.
- R7: While `tri_i` is high, `lock_o` is low from the next cycle on and the in-window run count is held at zero. After release, seven new in-window comparisons are needed before lock.
- R8: `lock_o` rises in the cycle after the seventh consecutive comparison whose pulse width is below `WIN_CYC` cycles (default 12). It stays high while further comparisons stay in the window.
- R9: A comparison whose pulse width is `WIN_CYC` cycles or more clears the run count, and `lock_o` is low from the next cycle.
- R10: After reset, `up_o`, `dn_o` and `lock_o` are low, `cur_code_o` is 2'b00 and `cur_units_o` is 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference divider output level |
| div_i | input | 1 | Main divider output level |
| tri_i | input | 1 | Pump off and lock detection off when high |
| cur_code_i | input | 2 | Requested pump current code |
| cur_load_i | input | 1 | One-cycle strobe that marks the end of a settings write |
| up_o | output | 1 | Pump source enable |
| dn_o | output | 1 | Pump sink enable |
| cur_code_o | output | 2 | Applied pump current code |
| cur_units_o | output | UNITS_W | Applied pump current magnitude in units |
| lock_o | output | 1 | Phase lock flag |

## Verification
An edge driven before clock edge P0 is detected at P0, so the pump enable is first visible after P0. The enable falls after the edge at which the other input's rise is detected. The bench drives each input at a falling clock edge and samples the outputs before driving, so the number of high samples equals the lead in cycles.

The lock flag settles one cycle after the deciding comparison, and a loaded code settles two cycles after its strobe. The bench waits at least two further falling edges before checking either. Vectors at widths 11 and 12 sit on both sides of the window.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    CUR_S1 = 2'b00,
    CUR_S2 = 2'b01,
    CUR_S3 = 2'b10,
    CUR_S4 = 2'b11
  } cur_code_e;

  // magnitude grows by one step per code value, starting at one step
  function automatic int unsigned code_units(cur_code_e c, int unsigned step);
    return (32'(c) + 32'd1) * step;
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] lvl_i,
  output logic [N_CH-1:0] rise_o
);

  logic [N_CH-1:0] prev_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int WIN_CYC = 12,
  localparam int CNT_W = $clog2(WIN_CYC + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic div_rise_i,
  input  logic tri_i,
  output logic up_o,
  output logic dn_o,
  output logic cmp_o,
  output logic win_ok_o,
  output logic idle_o
);

  logic up_q, dn_q, up_d, dn_d;
  logic ref_seen, div_seen, both_seen, active;
  logic [CNT_W-1:0] wid_q;

  assign ref_seen  = up_q | ref_rise_i;
  assign div_seen  = dn_q | div_rise_i;
  assign both_seen = ref_seen & div_seen;
  assign active    = up_q | dn_q;

  // both edges seen -> reset path clears both flops together
  always_comb begin
    up_d = !tri_i && ref_seen && !both_seen;
    dn_d = !tri_i && div_seen && !both_seen;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  // pulse width counter, saturates at the window limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                wid_q <= '0;
    else if (tri_i || both_seen)                wid_q <= '0;
    else if (active && wid_q != CNT_W'(WIN_CYC)) wid_q <= wid_q + 1'b1;
  end

  assign cmp_o    = !tri_i && both_seen;
  assign win_ok_o = (wid_q + {{(CNT_W-1){1'b0}}, active}) < CNT_W'(WIN_CYC);
  assign idle_o   = !up_q && !dn_q && !up_d && !dn_d;
  assign up_o     = up_q;
  assign dn_o     = dn_q;

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q));
  p_up_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tri_i && ref_rise_i && !div_rise_i && !dn_q) |=> up_q);
  p_dn_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tri_i && div_rise_i && !ref_rise_i && !up_q) |=> dn_q);
  p_both_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && div_rise_i) |=> (!up_q && !dn_q));
  p_tri_pump_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_i |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int LOCK_N = 7,
  localparam int LK_W = $clog2(LOCK_N + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic win_ok_i,
  input  logic tri_i,
  output logic lock_o
);

  logic [LK_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (tri_i)   run_q <= '0;
    else if (cmp_i) begin
      if (!win_ok_i)                      run_q <= '0;
      else if (run_q != LK_W'(LOCK_N))    run_q <= run_q + 1'b1;
    end
  end

  assign lock_o = (run_q == LK_W'(LOCK_N));

  p_miss_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && !win_ok_i && !tri_i) |=> !lock_o);
  p_tri_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_i |=> (!lock_o && run_q == '0));
  p_lock_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(cmp_i && win_ok_i && !tri_i));

endmodule

// File: rtl/pfd_cur_sync.sv
module pfd_cur_sync #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  input  logic              idle_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] pend_q, code_q;
  logic              pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      code_q     <= '0;
    end else begin
      if (load_i) begin
        pend_q     <= code_i;
        pend_vld_q <= 1'b1;
      end else if (pend_vld_q && idle_i) begin
        pend_vld_q <= 1'b0;
      end
      if (pend_vld_q && idle_i) code_q <= pend_q;
    end
  end

  assign code_o = code_q;

  p_code_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> $past(idle_i));

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int WIN_CYC   = 12,
  parameter int LOCK_N    = 7,
  parameter int UNIT_STEP = 50,
  parameter int UNITS_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_i,
  input  logic               div_i,
  input  logic               tri_i,
  input  logic [1:0]         cur_code_i,
  input  logic               cur_load_i,
  output logic               up_o,
  output logic               dn_o,
  output logic [1:0]         cur_code_o,
  output logic [UNITS_W-1:0] cur_units_o,
  output logic               lock_o
);

  logic [1:0] rise;
  logic       cmp, win_ok, idle;
  logic [1:0] code_app;

  pfd_edge #(.N_CH(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({div_i, ref_i}),
    .rise_o (rise)
  );

  pfd_core #(.WIN_CYC(WIN_CYC)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (rise[0]),
    .div_rise_i (rise[1]),
    .tri_i      (tri_i),
    .up_o       (up_o),
    .dn_o       (dn_o),
    .cmp_o      (cmp),
    .win_ok_o   (win_ok),
    .idle_o     (idle)
  );

  pfd_lock #(.LOCK_N(LOCK_N)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_i    (cmp),
    .win_ok_i (win_ok),
    .tri_i    (tri_i),
    .lock_o   (lock_o)
  );

  pfd_cur_sync #(.CODE_W(2)) u_cur (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (cur_code_i),
    .load_i (cur_load_i),
    .idle_i (idle),
    .code_o (code_app)
  );

  assign cur_code_o  = code_app;
  assign cur_units_o = UNITS_W'(code_units(cur_code_e'(code_app), UNIT_STEP));

  p_code_pump_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_code_o) |-> (!up_o && !dn_o && !$past(up_o) && !$past(dn_o)));

endmodule

// File: tb/tb_pfd_lock_top.sv
`timescale 1ns/1ps
module tb_pfd_lock_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_i = 1'b0, div_i = 1'b0, tri_i = 1'b0;
  logic [1:0] cur_code_i = 2'b00;
  logic       cur_load_i = 1'b0;
  logic       up_o, dn_o, lock_o;
  logic [1:0] cur_code_o;
  logic [7:0] cur_units_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pfd_lock_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .div_i(div_i), .tri_i(tri_i),
    .cur_code_i(cur_code_i), .cur_load_i(cur_load_i), .up_o(up_o), .dn_o(dn_o),
    .cur_code_o(cur_code_o), .cur_units_o(cur_units_o), .lock_o(lock_o)
  );

  // lead in cycles (+ reference first, - divider first) and lock expected after it
  localparam int NV = 12;
  localparam int VEC_D[NV]   = '{3, -2, 0, 5, -11, 1, 4, 6, 12, 2, -12, 11};
  localparam bit VEC_LCK[NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cmp(input int d, output int nup, output int ndn, output int nboth);
    int a;
    a = (d < 0) ? -d : d;
    nup = 0; ndn = 0; nboth = 0;
    for (int k = 0; k < a + 6; k++) begin
      @(negedge clk_i);
      if (up_o) nup++;
      if (dn_o) ndn++;
      if (up_o && dn_o) nboth++;
      if (k == 0) begin
        if (d >= 0) ref_i = 1'b1;
        if (d <= 0) div_i = 1'b1;
      end
      if (k == a) begin ref_i = 1'b1; div_i = 1'b1; end
      if (k == a + 2) begin ref_i = 1'b0; div_i = 1'b0; end
    end
  endtask

  task automatic cmp_checked(input int d);
    int nu, nd, nb, a;
    a = (d < 0) ? -d : d;
    run_cmp(d, nu, nd, nb);
    chk(nb == 0, "R3 overlap", nb, 0);
    if (d > 0) begin
      chk(nu == a, "R1 up width", nu, a);
      chk(nd == 0, "R1 dn idle", nd, 0);
    end else if (d < 0) begin
      chk(nd == a, "R2 dn width", nd, a);
      chk(nu == 0, "R2 up idle", nu, 0);
    end else begin
      chk(nu + nd == 0, "R3 coincident", nu + nd, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    chk(!up_o && !dn_o, "R10 pump", {up_o, dn_o}, 0);
    chk(!lock_o, "R10 lock", lock_o, 0);
    chk(cur_code_o == 2'b00, "R10 code", cur_code_o, 0);
    chk(cur_units_o == 8'd50, "R10 units", cur_units_o, 50);

    // R4 code map, R5 latency when idle
    for (int c = 3; c >= 0; c--) begin
      cur_code_i = 2'(c);
      cur_load_i = 1'b1;
      @(negedge clk_i);
      cur_load_i = 1'b0;
      chk(cur_code_o != 2'(c) || c == 0, "R5 early apply", cur_code_o, 3 - c == 0 ? 0 : c + 1);
      @(negedge clk_i);
      chk(cur_code_o == 2'(c), "R5 idle latency", cur_code_o, c);
      chk(cur_units_o == 8'((c + 1) * 50), "R4 units", cur_units_o, (c + 1) * 50);
    end

    // R5 hold while pump active
    cur_code_i = 2'b11; cur_load_i = 1'b1;
    @(negedge clk_i); cur_load_i = 1'b0;
    repeat (2) @(negedge clk_i);
    ref_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    cur_code_i = 2'b01; cur_load_i = 1'b1;
    @(negedge clk_i); cur_load_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(up_o == 1'b1, "R1 up held", up_o, 1);
    chk(cur_code_o == 2'b11, "R5 held while active", cur_code_o, 3);
    div_i = 1'b1;
    @(negedge clk_i);
    ref_i = 1'b0; div_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(cur_code_o == 2'b01, "R5 applied when idle", cur_code_o, 1);
    chk(cur_units_o == 8'd100, "R4 units after sync", cur_units_o, 100);

    // vector table: R1 R2 R3 R8 R9
    do_reset();
    for (int v = 0; v < NV; v++) begin
      cmp_checked(VEC_D[v]);
      repeat (2) @(negedge clk_i);
      chk(lock_o == VEC_LCK[v], VEC_D[v] >= 12 || VEC_D[v] <= -12 ? "R9 lock" : "R8 lock",
          lock_o, VEC_LCK[v]);
    end

    // R6 R7 tri-state
    for (int i = 0; i < 7; i++) cmp_checked(2);
    repeat (2) @(negedge clk_i);
    chk(lock_o == 1'b1, "R8 relock", lock_o, 1);
    tri_i = 1'b1;
    @(negedge clk_i);
    chk(lock_o == 1'b0, "R7 tri lock", lock_o, 0);
    begin
      int nu, nd, nb;
      run_cmp(5, nu, nd, nb);
      chk(nu + nd == 0, "R6 tri pump", nu + nd, 0);
    end
    chk(lock_o == 1'b0, "R7 tri lock held", lock_o, 0);
    @(negedge clk_i);
    tri_i = 1'b0;
    for (int i = 0; i < 6; i++) cmp_checked(1);
    repeat (2) @(negedge clk_i);
    chk(lock_o == 1'b0, "R7 count restarted", lock_o, 0);
    cmp_checked(1);
    repeat (2) @(negedge clk_i);
    chk(lock_o == 1'b1, "R8 lock after seven", lock_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule